// File: doc/BRIEF.md
# Three-Phase Nine-Bit Microcontroller Core

A compact multicycle processor that runs programs made of 9-bit words held in a 16-word unified address space. Every instruction goes through three clock phases (fetch into the instruction register, operand latch, then execute and write back). The core holds a 4-bit program counter, a 9-bit instruction register, four general registers and a small adder/subtractor. The top two addresses are not storage: a read of address 14 returns the external input bus, and a write to address 15 drives the external output bus.

A program is placed in memory through a load port while reset is held. After reset is released, execution begins at address 0. The core halts when the program counter reaches the port addresses, either by stepping off address 13 or by a jump there. The output bus and the halt flag are the visible results.

Top module: `nano_core`

## Requirements
- R1: Reset is synchronous. It returns the sequencer to fetch and clears the program counter, the instruction register, all four registers and the output bus. It drives halt low and leaves memory contents untouched.
- R2: The load port writes progData into memory word progAddr (0..13) only on a clock edge where rst is high. A load strobe while rst is low has no effect.
- R3: Execution starts at address 0. Each instruction takes exactly three clock cycles, and any non-jump instruction advances the PC by one. For N executed instructions, halt rises on the 3N+1-th edge after reset is released.
- R4: The instruction layout is [8:6] opcode, [5:4] first register field, [3:2] second register field, and [3:0] address for memory and jump forms. A field value n selects register Rn (00=R0, 01=R1, 10=R2, 11=R3), and the four registers are independent.
- R5: Opcode 000 (subtract) sets R[5:4] = R[5:4] − R[3:2], modulo 512.
- R6: Opcode 001 (add) sets R[5:4] = R[5:4] + R[3:2], modulo 512. Bits [1:0] of register-form words are ignored.
- R7: Opcodes 010 (load) and 100 (read) set R[5:4] to the word at address [3:0]. Address 14 returns the input bus, address 15 returns the current output bus value, and addresses 0..13 return memory.
- R8: Opcodes 011 (store) and 101 (write) send R[5:4] to address [3:0]. Address 15 updates the output bus, address 14 discards the value, and addresses 0..13 update memory. The output bus changes at no other time.
- R9: Opcode 110 (jump) loads the PC with [3:0].
- R10: Opcode 111 (conditional branch) loads the PC with [3:0] when R[5:4] is nonzero; otherwise the PC advances by one.
- R11: When a fetch would read address 14 or 15, the core enters halt. Halt stays high until reset, and no register, PC or output changes while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| progWe | input | 1 | Program load strobe, honoured only during reset |
| progAddr | input | 4 | Memory word written by the load port |
| progData | input | 9 | Word written by the load port |
| inPort | input | 9 | External value returned by reads of address 14 |
| outPort | output | 9 | Value last written to address 15 |
| halt | output | 1 | High once the fetch address reaches the port region |

## Verification
Six short programs are run, each separating a different behaviour.
- A load/read/subtract/store/reload sequence with a forward jump shows that memory writes land and that the input port is distinct from storage.
- An addition that wraps past 511, with junk in the low bits, separates modulo arithmetic from masking errors.
- A subtraction that goes below zero exposes operand order.
- A counted loop exercises both outcomes of the conditional branch and checks the exact cycle count.
- A program that runs off the end of storage checks halting by increment.
- A program that touches all four registers, reads back the output port and stores to the input address exposes register aliasing and port decoding.

Directed runs then check the reset state, that load strobes outside reset are ignored, and that halt holds.

// File: rtl/nano_pkg.sv
package nano_pkg;
  localparam int OPC_W    = 3;
  localparam int RSEL_W   = 2;
  localparam int ADDR_W   = 4;
  localparam int WORD_W   = OPC_W + RSEL_W + ADDR_W;
  localparam int NUM_REGS = 2 ** RSEL_W;
  localparam int DEPTH    = 2 ** ADDR_W;

  localparam logic [ADDR_W-1:0] IN_ADDR  = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] OUT_ADDR = ADDR_W'(DEPTH - 1);

  typedef enum logic [OPC_W-1:0] {
    OP_SUB   = 3'd0,
    OP_ADD   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_READ  = 3'd4,
    OP_WRITE = 3'd5,
    OP_GOTO  = 3'd6,
    OP_BRIF  = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_HALT   = 2'd3
  } phase_e;

  typedef struct packed {
    logic irLoad;
    logic opLatch;
    logic regWe;
    logic wbFromBus;
    logic aluSub;
    logic memWe;
    logic pcInc;
    logic pcJump;
  } strobe_t;
endpackage

// File: rtl/nano_ctrl.sv
module nano_ctrl
  import nano_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opcode,
  input  logic    branchTaken,
  input  logic    pcAtPorts,
  output strobe_t st,
  output logic    halt
);
  phase_e phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phaseNext;
  end

  always_comb begin
    st        = '0;
    phaseNext = phase;
    unique case (phase)
      PH_FETCH: begin
        if (pcAtPorts) begin
          phaseNext = PH_HALT;
        end else begin
          st.irLoad = 1'b1;
          phaseNext = PH_DECODE;
        end
      end
      PH_DECODE: begin
        st.opLatch = 1'b1;
        phaseNext  = PH_EXEC;
      end
      PH_EXEC: begin
        phaseNext = PH_FETCH;
        unique case (opcode)
          OP_SUB: begin
            st.regWe  = 1'b1;
            st.aluSub = 1'b1;
            st.pcInc  = 1'b1;
          end
          OP_ADD: begin
            st.regWe = 1'b1;
            st.pcInc = 1'b1;
          end
          OP_LOAD, OP_READ: begin
            st.regWe     = 1'b1;
            st.wbFromBus = 1'b1;
            st.pcInc     = 1'b1;
          end
          OP_STORE, OP_WRITE: begin
            st.memWe = 1'b1;
            st.pcInc = 1'b1;
          end
          OP_GOTO: st.pcJump = 1'b1;
          OP_BRIF: begin
            if (branchTaken) st.pcJump = 1'b1;
            else             st.pcInc  = 1'b1;
          end
          default: st.pcInc = 1'b1;
        endcase
      end
      default: phaseNext = PH_HALT;
    endcase
  end

  assign halt = (phase == PH_HALT);

  // R3: execute is always followed by a new fetch
  p_exec_then_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC) |=> (phase == PH_FETCH));

  // R11: once halted, stay halted until reset
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R9: the PC never gets two update sources at once
  p_single_pc_source_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.pcInc, st.pcJump}));

  // R8: register writeback and memory write never coincide
  p_wb_or_store_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.regWe, st.memWe}));
endmodule

// File: rtl/nano_dpath.sv
module nano_dpath
  import nano_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             st,
  input  logic                progWe,
  input  logic [ADDR_W-1:0]   progAddr,
  input  logic [WORD_W-1:0]   progData,
  input  logic [WORD_W-1:0]   inPort,
  output logic [WORD_W-1:0]   outPort,
  output opcode_e             opcode,
  output logic                branchTaken,
  output logic                pcAtPorts
);
  localparam int DST_LSB = WORD_W - OPC_W - RSEL_W;
  localparam int SRC_LSB = DST_LSB - RSEL_W;

  logic [ADDR_W-1:0]                pc;
  logic [WORD_W-1:0]                ir;
  logic [NUM_REGS-1:0][WORD_W-1:0]  rf;
  logic [WORD_W-1:0]                opA, opB;
  logic [WORD_W-1:0]                outReg;
  logic [WORD_W-1:0]                mem [DEPTH];

  logic [RSEL_W-1:0] dstSel, srcSel;
  logic [ADDR_W-1:0] addrField;
  logic [WORD_W-1:0] busRead, aluOut, wbData;
  logic [NUM_REGS-1:0] regSel;

  assign dstSel    = ir[DST_LSB +: RSEL_W];
  assign srcSel    = ir[SRC_LSB +: RSEL_W];
  assign addrField = ir[ADDR_W-1:0];
  assign opcode    = opcode_e'(ir[WORD_W-1 -: OPC_W]);

  // program counter
  always_ff @(posedge clk) begin
    if (rst)            pc <= '0;
    else if (st.pcJump) pc <= addrField;
    else if (st.pcInc)  pc <= pc + 1'b1;
  end
  assign pcAtPorts = (pc >= IN_ADDR);

  // instruction register
  always_ff @(posedge clk) begin
    if (rst)            ir <= '0;
    else if (st.irLoad) ir <= mem[pc];
  end

  // operand latches
  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
    end else if (st.opLatch) begin
      opA <= rf[dstSel];
      opB <= rf[srcSel];
    end
  end
  assign branchTaken = (opA != '0);

  // memory-mapped read path
  always_comb begin
    if (addrField == IN_ADDR)       busRead = inPort;
    else if (addrField == OUT_ADDR) busRead = outReg;
    else                            busRead = mem[addrField];
  end

  assign aluOut = st.aluSub ? (opA - opB) : (opA + opB);
  assign wbData = st.wbFromBus ? busRead : aluOut;

  // register file with per-register write select
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_regsel
    assign regSel[g] = st.regWe && (dstSel == RSEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf <= '0;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (regSel[k]) rf[k] <= wbData;
      end
    end
  end

  // storage: loaded only in reset, written by stores below the port region
  always_ff @(posedge clk) begin
    if (rst) begin
      if (progWe && (progAddr < IN_ADDR)) mem[progAddr] <= progData;
    end else if (st.memWe && (addrField < IN_ADDR)) begin
      mem[addrField] <= opA;
    end
  end

  // output port
  always_ff @(posedge clk) begin
    if (rst)                                      outReg <= '0;
    else if (st.memWe && (addrField == OUT_ADDR)) outReg <= opA;
  end
  assign outPort = outReg;

  // R8: output bus changes only on a store cycle
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !st.memWe) |=> $stable(outReg));

  // R4: registers change only on a writeback cycle
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !st.regWe) |=> $stable(rf));

  // R3: PC moves only when the sequencer asks
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !st.pcInc && !st.pcJump) |=> $stable(pc));

  // R11: no instruction is ever fetched from the port region
  p_fetch_in_storage_r11: assert property (@(posedge clk) disable iff (rst)
    st.irLoad |-> (pc < IN_ADDR));
endmodule

// File: rtl/nano_core.sv
module nano_core
  import nano_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic [3:0]        progAddr,
  input  logic [8:0]        progData,
  input  logic [8:0]        inPort,
  output logic [8:0]        outPort,
  output logic              halt
);
  strobe_t st;
  opcode_e opcode;
  logic    branchTaken;
  logic    pcAtPorts;

  nano_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .branchTaken(branchTaken),
    .pcAtPorts  (pcAtPorts),
    .st         (st),
    .halt       (halt)
  );

  nano_dpath u_dpath (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .progWe     (progWe),
    .progAddr   (progAddr),
    .progData   (progData),
    .inPort     (inPort),
    .outPort    (outPort),
    .opcode     (opcode),
    .branchTaken(branchTaken),
    .pcAtPorts  (pcAtPorts)
  );
endmodule

// File: tb/nano_core_bench.sv
`timescale 1ns/1ps
module nano_core_bench;
  localparam int NV = 6;
  localparam int NW = 14;

  localparam logic [8:0] PROGS [NV][NW] = '{
    // 0: load, read port, subtract, jump, store, reload, write out
    '{9'b010_10_0100, 9'b100_11_1110, 9'b000_11_10_00, 9'b110_00_0110,
      9'd5, 9'd0, 9'b011_11_0101, 9'b010_00_0101, 9'b101_00_1111,
      9'b110_00_1110, 9'd0, 9'd0, 9'd0, 9'd0},
    // 1: add with wrap and junk low bits
    '{9'b010_01_1010, 9'b010_10_1011, 9'b001_01_10_11, 9'b101_01_1111,
      9'b110_00_1110, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0,
      9'd300, 9'd250, 9'd0, 9'd0},
    // 2: subtract below zero
    '{9'b100_00_1110, 9'b010_01_1010, 9'b000_00_01_00, 9'b101_00_1111,
      9'b110_00_1110, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0,
      9'd5, 9'd0, 9'd0, 9'd0},
    // 3: counted loop with conditional branch
    '{9'b010_01_1010, 9'b010_10_1011, 9'b010_11_1100, 9'b001_11_10_00,
      9'b000_01_10_00, 9'b111_01_0011, 9'b101_11_1111, 9'b110_00_1110,
      9'd0, 9'd0, 9'd3, 9'd1, 9'd0, 9'd0},
    // 4: run off the end of storage
    '{9'b100_10_1110, 9'b101_10_1111, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0,
      9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0},
    // 5: all registers, output readback, store to input address
    '{9'b010_10_1100, 9'b010_11_1101, 9'b011_11_1110, 9'b101_10_1111,
      9'b100_00_1111, 9'b100_01_1110, 9'b001_00_01_00, 9'b001_00_11_00,
      9'b000_00_10_00, 9'b101_00_1111, 9'b110_00_1110, 9'd0,
      9'd33, 9'd44}
  };
  localparam logic [8:0] IN_VALS [NV] = '{9'd7, 9'd0, 9'd3, 9'd0, 9'd421, 9'd7};
  localparam logic [8:0] EXP_OUT [NV] = '{9'd2, 9'd38, 9'd510, 9'd3, 9'd421, 9'd51};
  localparam int         STEPS   [NV] = '{8, 5, 5, 14, 14, 11};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       progWe = 1'b0;
  logic [3:0] progAddr = '0;
  logic [8:0] progData = '0;
  logic [8:0] inPort = '0;
  logic [8:0] outPort;
  logic       halt;

  int checks = 0;
  int errors = 0;
  int cycTotal = 0;

  always #2 clk = ~clk;

  nano_core u_nano_core (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .inPort(inPort), .outPort(outPort), .halt(halt)
  );

  function automatic string tagOf(int i);
    case (i)
      0: return "R5 R7 R8 R9";
      1: return "R4 R6";
      2: return "R5 R7";
      3: return "R10";
      4: return "R7 R11";
      default: return "R4 R7 R8";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadProg(int v);
    @(negedge clk);
    rst    = 1'b1;
    inPort = IN_VALS[v];
    for (int a = 0; a < NW; a++) begin
      progWe   = 1'b1;
      progAddr = 4'(a);
      progData = PROGS[v][a];
      @(negedge clk);
    end
    progWe = 1'b0;
  endtask

  task automatic runToHalt(output int cyc);
    cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halt && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int cyc;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(halt == 1'b0, "R1 halt in reset", int'(halt), 0);
    check(outPort == 9'd0, "R1 outPort in reset", int'(outPort), 0);

    for (int v = 0; v < NV; v++) begin
      loadProg(v);
      check(outPort == 9'd0, "R1 outPort after reload", int'(outPort), 0);
      runToHalt(cyc);
      check(outPort == EXP_OUT[v], tagOf(v), int'(outPort), int'(EXP_OUT[v]));
      check(cyc == 3 * STEPS[v] + 1, "R3 cycles to halt", cyc, 3 * STEPS[v] + 1);
    end

    // R11: halt is sticky and nothing moves while halted
    repeat (8) @(negedge clk);
    check(halt == 1'b1, "R11 halt sticky", int'(halt), 1);
    check(outPort == 9'd51, "R11 outPort frozen", int'(outPort), 51);

    // R2: load strobe while not in reset is ignored
    progWe   = 1'b1;
    progAddr = 4'd9;
    progData = 9'b101_10_1111;
    @(negedge clk);
    progWe = 1'b0;
    rst    = 1'b1;
    @(negedge clk);
    // R1: reset clears halt and output, keeps memory
    check(halt == 1'b0, "R1 halt cleared", int'(halt), 0);
    check(outPort == 9'd0, "R1 outPort cleared", int'(outPort), 0);
    runToHalt(cyc);
    check(outPort == 9'd51, "R2 program unchanged", int'(outPort), 51);
    check(cyc == 34, "R2 cycle count unchanged", cyc, 34);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule